// File: doc/BRIEF.md
# Receive Multicast Hash Filter

This block sits beside a receive MAC and watches each incoming Ethernet frame as a stream of bytes. It runs a CRC-32 over the frame. After the sixth byte, which ends the destination address, it captures a 6-bit hash taken from the CRC at that point. The hash picks one bit of a 64-bit group-address table, which is supplied as eight bytes. A frame whose destination is a group address passes the filter when its table bit is set.

When the last byte of a frame arrives, the block presents a status word for one cycle. The status word reports whether the destination was broadcast or multicast, whether the frame check failed or a line error was seen, whether the byte count was odd, and whether the frame was over or under the legal size. The hash value is also placed in the status word, so that software can reuse it when it searches its own group-address list.

Top module: `rmh_filter`

## Requirements
- R1: The CRC is the Ethernet CRC-32: polynomial 0x04C11DB7, preset to all ones, with each byte taken least significant bit first. The hash is the six most significant bits of that CRC, uncomplemented, as it stands after the six destination bytes. It is reported in status bits [11:6]. Examples: first byte ED with five zero bytes gives hash 000000. 0D gives 010000. 01 gives 100111. 2F gives 111111.
- R2: Hash bits [5:3] select table byte k, which is carried on mc_table[8k+7:8k]. Hash bits [2:0] select the bit within that byte. The selected bit is therefore mc_table[hash].
- R3: out_pass is 1 only when the frame holds at least six bytes, bit 0 of its first byte is 1, and the selected table bit is 1. Otherwise out_pass is 0.
- R4: Status bit 5 (broadcast) is set when all 48 destination bits are 1. Status bit 4 (multicast) equals bit 0 of the first byte, so a broadcast frame also sets it.
- R5: Status bit 3 (bad CRC) is set when the CRC over the whole frame, including the 4-byte check field, does not leave the good-frame remainder. It is also set when rx_err was 1 on any accepted byte of the frame.
- R6: Status bit 2 is set when the frame byte count is odd.
- R7: Status bit 1 is set when the byte count exceeds 1518. Status bit 0 is set when the byte count is below 64. Both counts include the check field. The internal counter saturates instead of wrapping.
- R8: out_valid pulses high for exactly the one cycle after a byte that carries in_eof. Status and pass are valid in that cycle. out_valid is low in every other cycle.
- R9: A byte that carries in_sof starts a new frame. Count, CRC, address and error state from any unfinished earlier frame have no effect on the new frame.
- R10: While rst is high, out_valid and out_pass go low and out_status goes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is presented on in_data |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of a frame (qualified by in_valid) |
| in_eof | input | 1 | Last byte of a frame (qualified by in_valid) |
| rx_err | input | 1 | Line error indication, sampled with each accepted byte |
| mc_table | input | 64 | Group-address table, byte k on bits 8k+7:8k |
| out_valid | output | 1 | One-cycle strobe for status and pass |
| out_pass | output | 1 | Frame passes group-address filtering |
| out_status | output | 12 | {hash[5:0], bcast, mcast, bad_crc, odd, too_long, too_short} |

## Verification
On every cycle, the assertions check that the output strobe appears exactly one cycle after an end marker. They also check that a pass never appears without the multicast flag, that broadcast always carries multicast, that the two length flags never occur together, and that the length counter holds at saturation. Only the bench's scenarios can show the correct hash and table-bit choice, including the four fixed address examples. The same holds for the CRC verdict on good and corrupted frames, line errors and abandoned frames, and the length flags at 63, 64, 1518 and 1519 bytes.

// File: rtl/rmh_pkg.sv
package rmh_pkg;
    localparam int          CRC_W       = 32;
    localparam logic [31:0] CRC_PRESET  = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_LE = 32'hEDB8_8320;
    localparam logic [31:0] CRC_GOOD    = 32'hDEBB_20E3;
    localparam int          DA_BYTES    = 6;
    localparam int          HASH_W      = 6;
    localparam int          SEL_W       = 3;

    typedef struct packed {
        logic [SEL_W-1:0] byte_sel;
        logic [SEL_W-1:0] bit_sel;
    } hash_t;

    typedef struct packed {
        hash_t hash;
        logic  bcast;
        logic  mcast;
        logic  crc_bad;
        logic  odd_len;
        logic  over_len;
        logic  under_len;
    } rx_status_t;

    localparam int STATUS_W = $bits(rx_status_t);

    // one byte through the LSB-first CRC register
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [7:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_LE;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // top CRC bits live at the low end of the LSB-first register, reversed
    function automatic hash_t hash_of(input logic [CRC_W-1:0] c);
        logic [HASH_W-1:0] h;
        for (int i = 0; i < HASH_W; i++) h[HASH_W-1-i] = c[i];
        return hash_t'(h);
    endfunction
endpackage

// File: rtl/rmh_crc_acc.sv
module rmh_crc_acc
    import rmh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             sof,
    input  logic [7:0]       data,
    output logic [CRC_W-1:0] crc_next
);
    logic [CRC_W-1:0] crc_q;

    always_comb begin
        crc_next = crc_q;
        if (valid) crc_next = crc_step(sof ? CRC_PRESET : crc_q, data);
    end

    always_ff @(posedge clk) begin
        if (rst) crc_q <= CRC_PRESET;
        else     crc_q <= crc_next;
    end
endmodule

// File: rtl/rmh_len_count.sv
module rmh_len_count #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             sof,
    output logic [LEN_W-1:0] cnt_next
);
    localparam logic [LEN_W-1:0] SAT = {LEN_W{1'b1}};

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] base;

    always_comb begin
        base     = sof ? '0 : cnt_q;
        cnt_next = cnt_q;
        if (valid) cnt_next = (base == SAT) ? SAT : base + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_next;
    end

    assert_len_saturates_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == SAT && valid && !sof) |=> (cnt_q == SAT));
endmodule

// File: rtl/rmh_addr_track.sv
module rmh_addr_track
    import rmh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             sof,
    input  logic [7:0]       data,
    input  logic [CRC_W-1:0] crc_next,
    output logic             da_done_next,
    output logic             mcast_next,
    output logic             bcast_next,
    output hash_t            hash_next
);
    localparam int IDX_W = $clog2(DA_BYTES + 1);
    localparam logic [IDX_W-1:0] DA_END = IDX_W'(DA_BYTES);

    logic [IDX_W-1:0] idx_q, idx_n, base;
    logic             mc_q, bc_q;
    hash_t            h_q;

    always_comb begin
        idx_n      = idx_q;
        mcast_next = mc_q;
        bcast_next = bc_q;
        hash_next  = h_q;
        base       = sof ? '0 : idx_q;
        if (valid) begin
            idx_n = base;
            if (sof) begin
                mcast_next = 1'b0;
                bcast_next = 1'b1;
            end
            if (base < DA_END) begin
                idx_n = base + 1'b1;
                if (base == '0) mcast_next = data[0];
                bcast_next = bcast_next & (data == 8'hFF);
                if (base == DA_END - 1'b1) hash_next = hash_of(crc_next);
            end
        end
        da_done_next = (idx_n == DA_END);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            mc_q  <= 1'b0;
            bc_q  <= 1'b0;
            h_q   <= '0;
        end else begin
            idx_q <= idx_n;
            mc_q  <= mcast_next;
            bc_q  <= bcast_next;
            h_q   <= hash_next;
        end
    end

    assert_addr_index_bound_R3: assert property (@(posedge clk) disable iff (rst)
        idx_q <= DA_END);
endmodule

// File: rtl/rmh_filter.sv
module rmh_filter
    import rmh_pkg::*;
#(
    parameter int MAX_LEN = 1518,
    parameter int MIN_LEN = 64,
    parameter int LEN_W   = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    input  logic                in_sof,
    input  logic                in_eof,
    input  logic                rx_err,
    input  logic [63:0]         mc_table,
    output logic                out_valid,
    output logic                out_pass,
    output logic [STATUS_W-1:0] out_status
);
    localparam int TBL_BYTES = 1 << SEL_W;

    logic [CRC_W-1:0] crc_n;
    logic [LEN_W-1:0] len_n;
    logic             da_done_n, mc_n, bc_n;
    hash_t            hash_n;
    logic             err_q, err_n;
    logic [7:0]       tbl_byte [TBL_BYTES];
    logic             tbl_hit;
    rx_status_t       st_n, st_q;
    logic             frame_end;

    rmh_crc_acc u_crc (
        .clk(clk), .rst(rst), .valid(in_valid), .sof(in_sof),
        .data(in_data), .crc_next(crc_n)
    );

    rmh_len_count #(.LEN_W(LEN_W)) u_len (
        .clk(clk), .rst(rst), .valid(in_valid), .sof(in_sof), .cnt_next(len_n)
    );

    rmh_addr_track u_addr (
        .clk(clk), .rst(rst), .valid(in_valid), .sof(in_sof), .data(in_data),
        .crc_next(crc_n), .da_done_next(da_done_n), .mcast_next(mc_n),
        .bcast_next(bc_n), .hash_next(hash_n)
    );

    generate
        for (genvar k = 0; k < TBL_BYTES; k++) begin : g_tbl
            assign tbl_byte[k] = mc_table[8*k +: 8];
        end
    endgenerate

    assign tbl_hit   = tbl_byte[hash_n.byte_sel][hash_n.bit_sel];
    assign frame_end = in_valid && in_eof;

    always_comb begin
        err_n = err_q;
        if (in_valid) err_n = (in_sof ? 1'b0 : err_q) | rx_err;
    end

    always_comb begin
        st_n.hash      = hash_n;
        st_n.bcast     = bc_n & da_done_n;
        st_n.mcast     = mc_n;
        st_n.crc_bad   = (crc_n != CRC_GOOD) | err_n;
        st_n.odd_len   = len_n[0];
        st_n.over_len  = (len_n > LEN_W'(MAX_LEN));
        st_n.under_len = (len_n < LEN_W'(MIN_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q     <= 1'b0;
            out_valid <= 1'b0;
            out_pass  <= 1'b0;
            st_q      <= '0;
        end else begin
            err_q     <= err_n;
            out_valid <= frame_end;
            out_pass  <= frame_end && da_done_n && mc_n && tbl_hit;
            if (frame_end) st_q <= st_n;
        end
    end

    assign out_status = st_q;

    assert_strobe_follows_eof_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid && in_eof));
    assert_eof_yields_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_eof) |=> out_valid);
    assert_pass_needs_group_R3: assert property (@(posedge clk) disable iff (rst)
        out_pass |-> (out_valid && st_q.mcast));
    assert_bcast_has_mcast_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && st_q.bcast) |-> st_q.mcast);
    assert_len_flags_apart_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(st_q.over_len && st_q.under_len));

    initial begin
        assert_len_width_R7: assert ((1 << LEN_W) - 1 > MAX_LEN);
    end
endmodule

// File: tb/rmh_filter_tb.sv
module rmh_filter_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sof, in_eof, rx_err;
    logic [7:0]  in_data;
    logic [63:0] mc_table;
    logic        out_valid, out_pass;
    logic [11:0] out_status;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] fbuf [0:1599];

    always #4 clk = ~clk;

    rmh_filter u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .rx_err(rx_err), .mc_table(mc_table),
        .out_valid(out_valid), .out_pass(out_pass), .out_status(out_status)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < 8; b++)
                r = (r[0] ^ fbuf[i][b]) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        return r;
    endfunction

    function automatic logic [5:0] ref_hash();
        logic [31:0] r = ref_crc(6);
        logic [5:0]  h;
        for (int i = 0; i < 6; i++) h[5-i] = r[i];
        return h;
    endfunction

    // fill a frame: destination, random body, correct check field
    task automatic build(input int len, input logic [47:0] da);
        logic [31:0] fcs;
        for (int i = 0; i < len; i++) fbuf[i] = 8'($urandom);
        for (int i = 0; i < 6 && i < len; i++) fbuf[i] = da[47-8*i -: 8];
        if (len >= 10) begin
            fcs = ~ref_crc(len - 4);
            for (int k = 0; k < 4; k++) fbuf[len-4+k] = fcs[8*k +: 8];
        end
    endtask

    task automatic drive(input int len, input int err_at);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fbuf[i];
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            rx_err   = (i == err_at);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; rx_err = 1'b0;
    endtask

    // send, then compare the strobe cycle and the cycle after it
    task automatic run(input int len, input int err_at, input string tag);
        logic [5:0]  h;
        logic        mc, bc, bad, pass_e;
        logic [11:0] st_e, mask;
        h  = ref_hash();
        mc = fbuf[0][0];
        bc = (len >= 6);
        for (int i = 0; i < 6 && i < len; i++) bc = bc & (fbuf[i] == 8'hFF);
        bad    = (ref_crc(len) != 32'hDEBB_20E3) || (err_at >= 0);
        pass_e = (len >= 6) && mc && mc_table[h];
        st_e   = {h, bc, mc, bad, len[0], (len > 1518), (len < 64)};
        mask   = (len >= 6) ? 12'hFFF : 12'h03F;
        drive(len, err_at);
        chk(out_valid === 1'b1, {"R8 strobe ", tag}, 64'(out_valid), 64'd1);
        chk((out_status & mask) === (st_e & mask), {"R1 R2 R4 R5 R6 R7 status ", tag},
            64'(out_status & mask), 64'(st_e & mask));
        chk(out_pass === pass_e, {"R3 pass ", tag}, 64'(out_pass), 64'(pass_e));
        @(negedge clk);
        chk(out_valid === 1'b0, {"R8 single pulse ", tag}, 64'(out_valid), 64'd0);
    endtask

    task automatic vector(input logic [7:0] b0, input logic [5:0] h_e);
        mc_table = 64'd0;
        mc_table[h_e] = 1'b1;
        build(64, {b0, 40'd0});
        chk(ref_hash() === h_e, "R1 bench model vs vector", 64'(ref_hash()), 64'(h_e));
        run(64, -1, "R1 R2 vector");
        chk(out_status[11:6] === h_e, "R1 hash vector", 64'(out_status[11:6]), 64'(h_e));
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        rx_err = 1'b0; in_data = 8'd0; mc_table = 64'd0;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0 && out_pass === 1'b0 && out_status === 12'd0,
            "R10 reset state", {51'd0, out_valid, out_status}, 64'd0);
        rst = 1'b0;

        vector(8'hED, 6'b000000);
        vector(8'h0D, 6'b010000);
        vector(8'h01, 6'b100111);
        vector(8'h2F, 6'b111111);

        // table bit clear: group frame must not pass (R3)
        build(64, {8'h01, 40'd0});
        mc_table = ~(64'd1 << ref_hash());
        run(64, -1, "R3 bit clear");
        // individual address never passes (R3)
        mc_table = '1;
        build(80, 48'h0200_0000_0001);
        run(80, -1, "R3 individual");
        // broadcast (R4)
        build(70, 48'hFFFF_FFFF_FFFF);
        run(70, -1, "R4 broadcast");
        // line error and corrupted body (R5)
        build(100, 48'h0100_5E00_0001);
        run(100, 40, "R5 rx_err");
        build(100, 48'h0100_5E00_0001);
        fbuf[50] = fbuf[50] ^ 8'h10;
        run(100, -1, "R5 corrupt");
        // length edges (R6 R7)
        build(63, 48'h0100_5E00_0002);   run(63, -1, "R7 63");
        build(64, 48'h0100_5E00_0002);   run(64, -1, "R7 64");
        build(1518, 48'h0100_5E00_0003); run(1518, -1, "R7 1518");
        build(1519, 48'h0100_5E00_0003); run(1519, -1, "R6 R7 1519");
        build(3, 48'h0100_0000_0000);    run(3, -1, "R3 R7 tiny");

        // abandoned frame with error, then a clean frame (R9)
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'($urandom); in_sof = (i == 0);
            in_eof = 1'b0; rx_err = 1'b1;
        end
        @(negedge clk);
        in_valid = 1'b0; rx_err = 1'b0; in_sof = 1'b0;
        chk(out_valid === 1'b0, "R9 no strobe mid-frame", 64'(out_valid), 64'd0);
        mc_table = 64'($urandom) << 32 | 64'($urandom);
        build(90, 48'h0100_5E7F_0010);
        run(90, -1, "R9 restart");

        // random frames (R1-style mix)
        for (int f = 0; f < 40; f++) begin
            logic [47:0] da;
            int len;
            mc_table = (64'($urandom) << 32) | 64'($urandom);
            da  = {16'($urandom), 32'($urandom)};
            len = 6 + int'($urandom % 150);
            build(len, da);
            if (f % 7 == 3) fbuf[len/2] = ~fbuf[len/2];
            run(len, (f % 9 == 5) ? len - 1 : -1, "R1 R2 R3 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule